// File: doc/BRIEF.md
# Priority Flow Control Request Scheduler

This block watches how full the receive FIFO of one traffic priority is and decides when the transmitter should send a priority flow control frame. Two thresholds give it hysteresis. When the fill level rises above the upper threshold, the block asks for a pause frame. That frame carries the enable bit of this priority and the programmed pause quanta. When the level falls below the lower threshold, congestion is over.

While congestion lasts, a refresh timer sends the pause request again before the partner's pause runs out. The timer counts quantum ticks, where one quantum is 512 bit times at the current line speed. When congestion clears, one of two things happens, chosen by a mode bit:
- a frame with zero quanta is sent, so the partner resumes at once; or
- nothing is sent, and the partner's pause runs out on its own.

Requests leave on a valid/ready handshake. The quanta field always shows the latest decision, up to the cycle in which the request is accepted. A small set of configuration registers is written through a simple write strobe. Frame assembly, CRC and the receive-side pause timer belong to other blocks.

Top module: `pfc_req_sched`

## Requirements
- R1: After synchronous reset the block is not congested and `req_valid` is 0. The configuration resets to these values:
  - upper threshold 7/8 of `DEPTH` (896 for 1024);
  - lower threshold 3/4 of `DEPTH` (768);
  - pause quanta 0xFFFF;
  - refresh count 0xFF00;
  - zero-quanta release off.
- R2: When the block is not congested and `fifo_level` is strictly above the effective upper threshold at a clock edge, `req_valid` is 1 after that edge. `req_quanta` then equals the quanta register, and `req_prio_en` has only bit `PRIO_SEL` set.
- R3: A level between the two thresholds, boundaries included, leaves the congestion state unchanged and creates no request.
- R4: With zero-quanta release off, a level strictly below the effective lower threshold while congested ends congestion. After that edge `req_valid` is 0, and a pending pause request is withdrawn.
- R5: With zero-quanta release on, the same event makes `req_valid` 1 after the edge, with `req_quanta` equal to 0x0000.
- R6: A request stays valid while `req_ready` is 0, unless R4 withdraws it. `req_valid` falls in the cycle after an edge where both `req_valid` and `req_ready` are 1 and no new event occurs.
- R7: If the congestion decision changes while a request is pending, the pending request takes on the new quanta value: 0x0000 for release, the quanta register for pause.
- R8: Once a pause request has been accepted and congestion lasts, a new pause request appears after the edge carrying the N-th `tick_q` pulse, where N is the refresh count. Clock edges without `tick_q` do not advance the count.
- R9: When congestion ends, the refresh count is cleared. No further pause request comes from ticks until congestion begins again.
- R10: The effective upper threshold is the programmed value, or 1 if that value is 0. The effective lower threshold is the programmed value, or the effective upper threshold minus 1 if the programmed value is not below it.
- R11: A write with `cfg_wr` = 1 takes effect from the next edge. The registers selected by `cfg_addr` are:
  - 0: upper threshold, from the low bits of `cfg_wdata`;
  - 1: lower threshold, from the low bits;
  - 2: pause quanta;
  - 3: refresh count;
  - 4: bit 0 enables zero-quanta release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_level | input | LVL_W | Fill level of the watched receive FIFO |
| tick_q | input | 1 | One-cycle pulse per pause quantum at line speed |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | Q_W | Configuration write data |
| req_ready | input | 1 | Transmitter accepts the pending request |
| req_valid | output | 1 | A frame request is pending |
| req_prio_en | output | PRIO_CNT | Priority-enable vector of the frame |
| req_quanta | output | Q_W | Pause time for this priority in the frame |

## Verification
The hardest situations to reach are those where the congestion decision changes while a request waits for `req_ready`. Examples are a release frame overtaken by a new congestion, a pending pause withdrawn by silent release, and a refresh timer that is armed only by acceptance and cleared by release. The directed part builds each of these by holding `req_ready` low across a level change. The random part sets a small refresh count and sweeps the level in a random walk across both thresholds, with sparse ticks and random readiness. In this way refresh, acceptance and release overlap in many orders, and the bench's own model is compared every cycle.

// File: rtl/pfc_req_pkg.sv
package pfc_req_pkg;

  typedef enum logic [2:0] {
    CFG_XOFF_THR = 3'd0,
    CFG_XON_THR  = 3'd1,
    CFG_QUANTA   = 3'd2,
    CFG_REFRESH  = 3'd3,
    CFG_MODE     = 3'd4
  } cfg_addr_e;

  typedef enum logic {
    REQ_PAUSE   = 1'b0,
    REQ_RELEASE = 1'b1
  } req_kind_e;

  // Upper threshold may not be zero.
  function automatic int unsigned eff_upper(int unsigned prog);
    return (prog == 0) ? 1 : prog;
  endfunction

  // Lower threshold is kept strictly below the effective upper one.
  function automatic int unsigned eff_lower(int unsigned prog, int unsigned upper);
    return (prog >= upper) ? upper - 1 : prog;
  endfunction

  // True when the tick now being counted completes the refresh period.
  function automatic bit refresh_due(int unsigned cnt, int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs
  import pfc_req_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int LVL_W = 11,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_addr,
  input  logic [Q_W-1:0]   cfg_wdata,
  output logic [LVL_W-1:0] upper_eff,
  output logic [LVL_W-1:0] lower_eff,
  output logic [Q_W-1:0]   quanta,
  output logic [Q_W-1:0]   refresh,
  output logic             auto_rel
);
  localparam int UPPER_DEF = (DEPTH * 7) / 8;
  localparam int LOWER_DEF = (DEPTH * 3) / 4;
  localparam logic [Q_W-1:0] QUANTA_DEF  = '1;
  localparam logic [Q_W-1:0] REFRESH_DEF = {8'hFF, {(Q_W-8){1'b0}}};

  logic [LVL_W-1:0] upper_r, lower_r;
  logic [Q_W-1:0]   quanta_r, refresh_r;
  logic             auto_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_r   <= LVL_W'(UPPER_DEF);
      lower_r   <= LVL_W'(LOWER_DEF);
      quanta_r  <= QUANTA_DEF;
      refresh_r <= REFRESH_DEF;
      auto_r    <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        CFG_XOFF_THR: upper_r   <= cfg_wdata[LVL_W-1:0];
        CFG_XON_THR:  lower_r   <= cfg_wdata[LVL_W-1:0];
        CFG_QUANTA:   quanta_r  <= cfg_wdata;
        CFG_REFRESH:  refresh_r <= cfg_wdata;
        CFG_MODE:     auto_r    <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  logic [LVL_W-1:0] up_fix;
  assign up_fix    = LVL_W'(eff_upper(32'(upper_r)));
  assign upper_eff = up_fix;
  assign lower_eff = LVL_W'(eff_lower(32'(lower_r), 32'(up_fix)));
  assign quanta    = quanta_r;
  assign refresh   = refresh_r;
  assign auto_rel  = auto_r;
endmodule

// File: rtl/pfc_hyst.sv
module pfc_hyst #(
  parameter int LVL_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] upper_eff,
  input  logic [LVL_W-1:0] lower_eff,
  output logic             cong,
  output logic             set_ev,
  output logic             clr_ev
);
  logic cong_r;
  logic above, below;

  assign above  = level > upper_eff;
  assign below  = level < lower_eff;
  assign set_ev = !cong_r && above;
  assign clr_ev = cong_r && below;

  always_ff @(posedge clk) begin
    if (rst)         cong_r <= 1'b0;
    else if (set_ev) cong_r <= 1'b1;
    else if (clr_ev) cong_r <= 1'b0;
  end

  assign cong = cong_r;
endmodule

// File: rtl/pfc_refresh_tmr.sv
module pfc_refresh_tmr
  import pfc_req_pkg::*;
#(
  parameter int Q_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           arm,
  input  logic           stop,
  input  logic [Q_W-1:0] limit,
  output logic           fire,
  output logic           armed
);
  logic           armed_r;
  logic [Q_W-1:0] cnt_r;
  logic           due;

  assign due  = refresh_due(32'(cnt_r), 32'(limit));
  assign fire = armed_r && tick && !stop && !arm && due;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      armed_r <= 1'b0;
      cnt_r   <= '0;
    end else if (arm) begin
      armed_r <= 1'b1;
      cnt_r   <= '0;
    end else if (armed_r && tick) begin
      if (due) begin
        armed_r <= 1'b0;
        cnt_r   <= '0;
      end else begin
        cnt_r <= cnt_r + 1'b1;
      end
    end
  end

  assign armed = armed_r;
endmodule

// File: rtl/pfc_req_hold.sv
module pfc_req_hold
  import pfc_req_pkg::*;
#(
  parameter int Q_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_ev,
  input  logic           clr_ev,
  input  logic           fire,
  input  logic           auto_rel,
  input  logic           ready,
  input  logic [Q_W-1:0] quanta_cfg,
  output logic           valid,
  output logic           is_rel,
  output logic           pause_acc,
  output logic [Q_W-1:0] quanta
);
  logic      valid_r, valid_n;
  req_kind_e kind_r, kind_n;

  always_comb begin
    valid_n = valid_r;
    kind_n  = kind_r;
    if (valid_r && ready) valid_n = 1'b0;
    if (set_ev || fire) begin
      valid_n = 1'b1;
      kind_n  = REQ_PAUSE;
    end else if (clr_ev) begin
      valid_n = auto_rel;
      kind_n  = REQ_RELEASE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= 1'b0;
      kind_r  <= REQ_PAUSE;
    end else begin
      valid_r <= valid_n;
      kind_r  <= kind_n;
    end
  end

  assign valid     = valid_r;
  assign is_rel    = (kind_r == REQ_RELEASE);
  assign pause_acc = valid_r && ready && (kind_r == REQ_PAUSE);
  assign quanta    = is_rel ? '0 : quanta_cfg;
endmodule

// File: rtl/pfc_req_sched.sv
module pfc_req_sched #(
  parameter int DEPTH    = 1024,
  parameter int Q_W      = 16,
  parameter int PRIO_CNT = 8,
  parameter int PRIO_SEL = 0,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LVL_W-1:0]    fifo_level,
  input  logic                tick_q,
  input  logic                cfg_wr,
  input  logic [2:0]          cfg_addr,
  input  logic [Q_W-1:0]      cfg_wdata,
  input  logic                req_ready,
  output logic                req_valid,
  output logic [PRIO_CNT-1:0] req_prio_en,
  output logic [Q_W-1:0]      req_quanta
);
  logic [LVL_W-1:0] upper_eff, lower_eff;
  logic [Q_W-1:0]   quanta_cfg, refresh_cfg;
  logic             auto_rel;
  logic             cong, set_ev, clr_ev;
  logic             fire, armed;
  logic             is_rel, pause_acc;

  pfc_cfg_regs #(.DEPTH(DEPTH), .LVL_W(LVL_W), .Q_W(Q_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .upper_eff(upper_eff), .lower_eff(lower_eff),
    .quanta(quanta_cfg), .refresh(refresh_cfg), .auto_rel(auto_rel)
  );

  pfc_hyst #(.LVL_W(LVL_W)) u_hyst (
    .clk(clk), .rst(rst), .level(fifo_level), .upper_eff(upper_eff),
    .lower_eff(lower_eff), .cong(cong), .set_ev(set_ev), .clr_ev(clr_ev)
  );

  pfc_refresh_tmr #(.Q_W(Q_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick_q), .arm(pause_acc), .stop(clr_ev),
    .limit(refresh_cfg), .fire(fire), .armed(armed)
  );

  pfc_req_hold #(.Q_W(Q_W)) u_hold (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr_ev(clr_ev), .fire(fire),
    .auto_rel(auto_rel), .ready(req_ready), .quanta_cfg(quanta_cfg),
    .valid(req_valid), .is_rel(is_rel), .pause_acc(pause_acc),
    .quanta(req_quanta)
  );

  for (genvar g = 0; g < PRIO_CNT; g++) begin : g_prio
    assign req_prio_en[g] = (g == PRIO_SEL);
  end
endmodule

// File: rtl/pfc_req_sched_chk.sv
module pfc_req_sched_chk #(
  parameter int LVL_W = 11,
  parameter int Q_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [Q_W-1:0]   req_quanta,
  input logic             set_ev,
  input logic             clr_ev,
  input logic             cong,
  input logic             armed,
  input logic             is_rel,
  input logic             auto_rel,
  input logic [LVL_W-1:0] upper_eff,
  input logic [LVL_W-1:0] lower_eff
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready && !clr_ev |=> req_valid);

  // R2
  pause_req_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> req_valid && !is_rel);

  // R5
  rel_frame_chk: assert property (@(posedge clk) disable iff (rst)
    clr_ev && auto_rel |=> req_valid && req_quanta == '0);

  // R4
  rel_silent_chk: assert property (@(posedge clk) disable iff (rst)
    clr_ev && !auto_rel |=> !req_valid);

  // R3
  band_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !set_ev && !clr_ev |=> cong == $past(cong));

  // R9
  idle_timer_chk: assert property (@(posedge clk) disable iff (rst)
    !cong |-> !armed);

  // R10
  thr_order_chk: assert property (@(posedge clk) disable iff (rst)
    lower_eff < upper_eff);
endmodule

bind pfc_req_sched pfc_req_sched_chk #(.LVL_W(LVL_W), .Q_W(Q_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_quanta(req_quanta), .set_ev(set_ev), .clr_ev(clr_ev), .cong(cong),
  .armed(armed), .is_rel(is_rel), .auto_rel(auto_rel),
  .upper_eff(upper_eff), .lower_eff(lower_eff)
);

// File: tb/test_pfc_req_sched.sv
`timescale 1ns/1ps
module test_pfc_req_sched;
  localparam int DEPTH = 1024;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] fifo_level = '0;
  logic          tick_q = 1'b0, cfg_wr = 1'b0, req_ready = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          req_valid;
  logic [7:0]    req_prio_en;
  logic [15:0]   req_quanta;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfc_req_sched #(.DEPTH(DEPTH)) i_pfc_req_sched (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .tick_q(tick_q),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_ready(req_ready), .req_valid(req_valid),
    .req_prio_en(req_prio_en), .req_quanta(req_quanta)
  );

  // Bench model built from the requirements
  int m_up, m_lo, m_q, m_ref, m_cnt;
  bit m_auto, m_cong, m_val, m_rel, m_arm;

  function automatic int eup(int p); return (p == 0) ? 1 : p; endfunction
  function automatic int elo(int p, int u); return (p < u) ? p : u - 1; endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_up = DEPTH * 7 / 8; m_lo = DEPTH * 3 / 4; m_q = 16'hFFFF;
      m_ref = 16'hFF00; m_auto = 0; m_cong = 0; m_val = 0; m_rel = 0;
      m_arm = 0; m_cnt = 0;
    end else begin
      int u, l;
      bit go, stop, take, arm, rf;
      u = eup(m_up); l = elo(m_lo, u);
      go   = !m_cong && (int'(fifo_level) > u);
      stop = m_cong && (int'(fifo_level) < l);
      take = m_val && req_ready;
      arm  = take && !m_rel;
      rf   = 0;
      if (stop) begin m_arm = 0; m_cnt = 0; end
      else if (arm) begin m_arm = 1; m_cnt = 0; end
      else if (m_arm && tick_q) begin
        if (m_cnt + 1 >= m_ref) begin rf = 1; m_arm = 0; m_cnt = 0; end
        else m_cnt++;
      end
      if (take) m_val = 0;
      if (go || rf) begin m_val = 1; m_rel = 0; end
      else if (stop) begin m_val = m_auto; m_rel = 1; end
      if (go) m_cong = 1;
      else if (stop) m_cong = 0;
      if (cfg_wr) case (cfg_addr)
        3'd0: m_up = int'(cfg_wdata[LW-1:0]);
        3'd1: m_lo = int'(cfg_wdata[LW-1:0]);
        3'd2: m_q = int'(cfg_wdata);
        3'd3: m_ref = int'(cfg_wdata);
        3'd4: m_auto = cfg_wdata[0];
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    cfg_wr = 1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    cyc();
    cfg_wr = 0;
  endtask

  task automatic accept();
    req_ready = 1; cyc(); req_ready = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin tick_q = 1; cyc(); tick_q = 0; cyc(); end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 0; #0;
    chk("R1 reset valid", req_valid, 0);
    fifo_level = 896; cyc();
    chk("R1 default upper threshold not crossed", req_valid, 0);
    fifo_level = 897; cyc();
    chk("R2 pause request", req_valid, 1);
    chk("R1 default quanta", req_quanta, 16'hFFFF);
    chk("R2 priority enable", req_prio_en, 8'h01);
    cyc(3);
    chk("R6 held while not ready", req_valid, 1);
    accept();
    chk("R6 drops after accept", req_valid, 0);
    wr(3, 3);
    fifo_level = 800;
    ticks(2);
    chk("R8 no refresh before count", req_valid, 0);
    chk("R3 mid band no request", req_valid, 0);
    cyc(4);
    chk("R8 idle clocks do not count", req_valid, 0);
    ticks(1);
    chk("R8 refresh request", req_valid, 1);
    chk("R8 refresh quanta", req_quanta, 16'hFFFF);
    accept();
    fifo_level = 768; cyc();
    chk("R3 lower boundary holds", req_valid, 0);
    fifo_level = 767; cyc();
    chk("R4 silent release", req_valid, 0);
    ticks(5);
    chk("R9 no refresh after release", req_valid, 0);
    fifo_level = 897; cyc();
    fifo_level = 700; cyc();
    chk("R4 pending pause withdrawn", req_valid, 0);
    wr(4, 1);
    fifo_level = 897; cyc(); accept();
    fifo_level = 700; cyc();
    chk("R5 release frame valid", req_valid, 1);
    chk("R5 release quanta zero", req_quanta, 0);
    fifo_level = 897; cyc();
    chk("R7 pending updated to pause", req_valid, 1);
    chk("R7 pending quanta", req_quanta, 16'hFFFF);
    accept();
    fifo_level = 700; cyc(); accept();
    wr(2, 16'h1234);
    fifo_level = 897; cyc();
    chk("R11 quanta register", req_quanta, 16'h1234);
    accept();
    wr(0, 100); wr(1, 200);
    fifo_level = 99; cyc();
    chk("R10 clamped lower boundary holds", req_valid, 0);
    fifo_level = 98; cyc();
    chk("R10 clamped lower threshold releases", req_valid, 1);
    chk("R10 release quanta", req_quanta, 0);
    accept();

    // Random phase against the bench model
    rst = 1; cyc(2); rst = 0;
    wr(3, 4);
    begin
      int lvl;
      lvl = 760;
      void'($urandom(32'd1234));
      for (int i = 0; i < 6000; i++) begin
        lvl += int'($urandom_range(0, 40)) - 20;
        if (lvl < 0) lvl = 0;
        if (lvl > DEPTH) lvl = DEPTH;
        fifo_level = LW'(lvl);
        req_ready = ($urandom_range(0, 1) == 1);
        tick_q = ($urandom_range(0, 3) == 0);
        cfg_wr = 0;
        if ($urandom_range(0, 199) == 0) begin
          cfg_wr = 1; cfg_addr = 3'd4; cfg_wdata = 16'($urandom_range(0, 1));
        end else if ($urandom_range(0, 299) == 0) begin
          cfg_wr = 1; cfg_addr = 3'd2; cfg_wdata = 16'($urandom);
        end
        cyc();
        chk("R2 R4 R5 R6 R7 R8 R9 random valid", req_valid, m_val);
        if (m_val)
          chk("R2 R5 R7 random quanta", req_quanta, m_rel ? 0 : m_q);
      end
      cfg_wr = 0; tick_q = 0; req_ready = 0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule